// File: doc/BRIEF.md
# Split-Panel Refresh Address Generator

This block produces the display-memory addresses that refresh a dot-matrix LCD panel whose rows are divided into an upper half and a lower half that are scanned together. A dot counter divides the incoming dot clock into character periods. Each period fetches one byte for the upper half, while the character clock is low, and one byte for the lower half, while it is high. Every horizontal line is followed by eight dead character periods. During these periods the address keeps counting, but nothing is transferred.

In character mode the same row of character addresses is repeated once for every raster of the font height, and a raster row number is output for the character generator. In graphic mode every scan line takes a fresh row of bytes and the raster output stays at zero. An 8-bit register port programs the following values:
- the character width,
- the font height,
- the characters per line,
- the duty (lines per half),
- the 16-bit start address.

Scrolling is done by moving the start address. A step of HN moves the picture by one row, and a step of 1 moves it by one byte.

The memory address outputs carry either the refresh address or a CPU address, chosen by a select input. A float input releases both the address outputs and the raster outputs to high impedance.

Top module: `rfsh_addr_gen`

## Requirements
- R1: The dot counter counts modulo Hp, where Hp is 4..8 and is stored as Hp-1 in register index 1, bits [2:0]. `charClk` is low for the first floor(Hp/2) dots of each character period and high for the remaining dots.
- R2: While `charClk` is low, `memAddr` carries the upper address, which is the line base plus the character index. While `charClk` is high, it carries the upper address plus HN × rowsPerHalf. rowsPerHalf is Nx in graphic mode and Nx/Vp in character mode.
- R3: The character index advances when `charClk` falls. A line lasts HN+8 character periods, and the address keeps incrementing through the last 8 of them.
- R4: In graphic mode (register index 0, bit 0 = 1), the line base grows by HN at the end of every line and `rasterAddr` stays 0.
- R5: In character mode (index 0, bit 0 = 0), `rasterAddr` runs from 0 to Vp-1, one step per line. The line base grows by HN only after Vp lines.
- R6: A frame is Nx lines long. At the end of a frame, the counters return to zero and the line base reloads from the start register. A start address written mid-frame takes effect at the next frame.
- R7: All addresses wrap modulo 2^16.
- R8: With `refreshSel` low, `memAddr` equals `cpuAddr`.
- R9: With `outEn` low, `memAddr` and `rasterAddr` are high impedance.
- R10: A write with `regSel`=1 sets the 4-bit register index (wrData[3:0]). A write with `regSel`=0 loads the indexed register. The register map is:
  - index 2: Vp-1 in bits [3:0]
  - index 3: HN-1 in bits [6:0]
  - index 4: Nx-1 in bits [7:0]
  - index 5: start address low byte
  - index 6: start address high byte

  Reads with `regSel`=1 return {0000, index}. Reads with `regSel`=0 return the indexed register with unused bits zero. Indices 7..15 read zero and ignore writes.
- R11: Reset (`rstN` low, sampled on `clk`) clears the index register and all counters and loads the line base from the start register. The configuration registers keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Synchronous active-low reset |
| regSel | input | 1 | 1 selects the index register, 0 selects the indexed register |
| wrEn | input | 1 | Register write strobe, one write per clock |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| cpuAddr | input | 16 | CPU address passed to memory when refresh is not selected |
| refreshSel | input | 1 | 1 puts the refresh address on memAddr, 0 puts cpuAddr on memAddr |
| outEn | input | 1 | 0 floats memAddr and rasterAddr |
| charClk | output | 1 | Character clock; low = upper-half fetch, high = lower-half fetch |
| memAddr | output | 16 | Display memory address |
| rasterAddr | output | 4 | Raster row within a character (character mode) |

## Verification
The end of the last line of a frame is also the end of a line. The frame reload of the line base therefore coincides with the row step that would otherwise add HN, and the reload must win. This is provoked by running each configuration past its frame length and checking that the first fetch of the new frame returns to the start address, with the raster back at 0. A second collision comes from writing a new start address in the middle of a frame. The rest of that frame must still show the old rows, and the first character of the next frame must show the new base.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 4;
  localparam int DOT_W   = 3;
  localparam int CHAR_W  = 8;
  localparam int RAST_W  = 4;
  localparam int HN_W    = 7;
  localparam int DUTY_W  = 8;
  localparam int DEAD_CH = 8;

  typedef enum logic [IDX_W-1:0] {
    IDX_MODE   = 4'd0,
    IDX_HPITCH = 4'd1,
    IDX_VPITCH = 4'd2,
    IDX_CHARS  = 4'd3,
    IDX_DUTY   = 4'd4,
    IDX_STLO   = 4'd5,
    IDX_STHI   = 4'd6
  } regIdx_e;

  typedef struct packed {
    logic              graphic;
    logic [DOT_W-1:0]  hpM1;
    logic [RAST_W-1:0] vpM1;
    logic [HN_W-1:0]   hnM1;
    logic [DUTY_W-1:0] dutyM1;
    logic [ADDR_W-1:0] start;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rowStep;   // line end that moves to the next row of bytes
    logic frameEnd;  // last line of the frame ends this cycle
    logic load;      // reset: load base from start register
  } strobe_t;
endpackage

// File: rtl/rfsh_ctrl.sv
`timescale 1ns/1ps
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regSel,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output cfg_t                cfg,
  output strobe_t             strb,
  output logic [CHAR_W-1:0]   charIdx,
  output logic                charClk,
  output logic [RAST_W-1:0]   raster
);
  logic [IDX_W-1:0]  idxQ;
  cfg_t              cfgQ;
  logic [DOT_W-1:0]  dotCnt;
  logic [DUTY_W-1:0] lineCnt;
  logic [DOT_W:0]    hpFull;
  logic [DOT_W:0]    halfHp;
  logic [CHAR_W-1:0] lineLast;
  logic              dotEnd;
  logic              lineEnd;
  logic              frameEnd;

  // ---------------- register port ----------------
  always_ff @(posedge clk) begin
    if (!rstN) idxQ <= '0;
    else if (wrEn && regSel) idxQ <= wrData[IDX_W-1:0];
  end

  // configuration survives reset
  always_ff @(posedge clk) begin
    if (wrEn && !regSel) begin
      case (regIdx_e'(idxQ))
        IDX_MODE:   cfgQ.graphic <= wrData[0];
        IDX_HPITCH: cfgQ.hpM1    <= wrData[DOT_W-1:0];
        IDX_VPITCH: cfgQ.vpM1    <= wrData[RAST_W-1:0];
        IDX_CHARS:  cfgQ.hnM1    <= wrData[HN_W-1:0];
        IDX_DUTY:   cfgQ.dutyM1  <= wrData[DUTY_W-1:0];
        IDX_STLO:   cfgQ.start[DATA_W-1:0]      <= wrData;
        IDX_STHI:   cfgQ.start[ADDR_W-1:DATA_W] <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    if (regSel) rdData = DATA_W'(idxQ);
    else begin
      case (regIdx_e'(idxQ))
        IDX_MODE:   rdData = DATA_W'(cfgQ.graphic);
        IDX_HPITCH: rdData = DATA_W'(cfgQ.hpM1);
        IDX_VPITCH: rdData = DATA_W'(cfgQ.vpM1);
        IDX_CHARS:  rdData = DATA_W'(cfgQ.hnM1);
        IDX_DUTY:   rdData = DATA_W'(cfgQ.dutyM1);
        IDX_STLO:   rdData = cfgQ.start[DATA_W-1:0];
        IDX_STHI:   rdData = cfgQ.start[ADDR_W-1:DATA_W];
        default:    rdData = '0;
      endcase
    end
  end

  assign cfg = cfgQ;

  // ---------------- timing chain ----------------
  assign hpFull   = {1'b0, cfgQ.hpM1} + (DOT_W+1)'(1);
  assign halfHp   = hpFull >> 1;
  assign charClk  = ({1'b0, dotCnt} >= halfHp);
  assign lineLast = CHAR_W'(cfgQ.hnM1) + CHAR_W'(DEAD_CH);
  assign dotEnd   = (dotCnt >= cfgQ.hpM1);
  assign lineEnd  = dotEnd && (charIdx >= lineLast);
  assign frameEnd = lineEnd && (lineCnt >= cfgQ.dutyM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dotCnt  <= '0;
      charIdx <= '0;
      raster  <= '0;
      lineCnt <= '0;
    end else if (dotEnd) begin
      dotCnt <= '0;
      if (lineEnd) begin
        charIdx <= '0;
        if (frameEnd) begin
          lineCnt <= '0;
          raster  <= '0;
        end else begin
          lineCnt <= lineCnt + DUTY_W'(1);
          raster  <= (cfgQ.graphic || raster >= cfgQ.vpM1) ? '0 : raster + RAST_W'(1);
        end
      end else begin
        charIdx <= charIdx + CHAR_W'(1);
      end
    end else begin
      dotCnt <= dotCnt + DOT_W'(1);
    end
  end

  assign strb.rowStep  = lineEnd && (cfgQ.graphic || raster >= cfgQ.vpM1);
  assign strb.frameEnd = frameEnd;
  assign strb.load     = !rstN;

  // ---------------- assertions ----------------
  assert_wrap_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    dotEnd && cfgQ.hpM1 != '0 |=> !charClk || !$stable(cfgQ.hpM1))
    else $error("charClk not low after dot counter wrap");

  assert_fall_steps_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(charClk) && $stable(cfgQ.hpM1) |-> charIdx != $past(charIdx))
    else $error("charClk fell without character step");

  assert_graphic_raster_R4: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd && cfgQ.graphic |=> raster == '0)
    else $error("raster moved in graphic mode");

  assert_frame_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> raster == '0 && charIdx == '0 && lineCnt == '0)
    else $error("counters not cleared at frame end");
endmodule

// File: rtl/rfsh_datapath.sv
`timescale 1ns/1ps
module rfsh_datapath
  import rfsh_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                graphic,
  input  logic [RAST_W-1:0]   vpM1,
  input  logic [HN_W-1:0]     hnM1,
  input  logic [DUTY_W-1:0]   dutyM1,
  input  logic [ADDR_W-1:0]   start,
  input  logic [CHAR_W-1:0]   charIdx,
  input  logic                charClk,
  output logic [ADDR_W-1:0]   refreshAddr
);
  localparam int ROW_W = DUTY_W + 1;

  logic [ADDR_W-1:0] hnVal, lineBase, lowerOff, offNext, upperAddr, lowerAddr;
  logic [ROW_W-1:0]  nxVal, vpVal, rows;

  assign hnVal   = ADDR_W'(hnM1) + ADDR_W'(1);
  assign nxVal   = ROW_W'(dutyM1) + ROW_W'(1);
  assign vpVal   = ROW_W'(vpM1) + ROW_W'(1);
  assign rows    = graphic ? nxVal : nxVal / vpVal;
  assign offNext = ADDR_W'(hnVal * ADDR_W'(rows));

  always_ff @(posedge clk) begin
    if (strb.load || strb.frameEnd) begin
      lineBase <= start;
      lowerOff <= offNext;
    end else if (strb.rowStep) begin
      lineBase <= lineBase + hnVal;
    end
  end

  assign upperAddr   = lineBase + ADDR_W'(charIdx);
  assign lowerAddr   = upperAddr + lowerOff;
  assign refreshAddr = charClk ? lowerAddr : upperAddr;

  assert_row_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rowStep && !strb.frameEnd |=> lineBase == ADDR_W'($past(lineBase) + $past(hnVal)))
    else $error("line base did not step by HN");

  assert_frame_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameEnd |=> lineBase == $past(start))
    else $error("line base not reloaded at frame end");
endmodule

// File: rtl/rfsh_addr_gen.sv
`timescale 1ns/1ps
module rfsh_addr_gen
  import rfsh_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regSel,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                refreshSel,
  input  logic                outEn,
  output logic                charClk,
  output wire  [ADDR_W-1:0]   memAddr,
  output wire  [RAST_W-1:0]   rasterAddr
);
  cfg_t              cfg;
  strobe_t           strb;
  logic [CHAR_W-1:0] charIdx;
  logic [RAST_W-1:0] raster;
  logic [ADDR_W-1:0] refreshAddr;

  rfsh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cfg(cfg), .strb(strb), .charIdx(charIdx),
    .charClk(charClk), .raster(raster)
  );

  rfsh_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .graphic(cfg.graphic),
    .vpM1(cfg.vpM1), .hnM1(cfg.hnM1), .dutyM1(cfg.dutyM1), .start(cfg.start),
    .charIdx(charIdx), .charClk(charClk), .refreshAddr(refreshAddr)
  );

  assign memAddr    = outEn ? (refreshSel ? refreshAddr : cpuAddr) : {ADDR_W{1'bz}};
  assign rasterAddr = outEn ? raster : {RAST_W{1'bz}};
endmodule

// File: tb/rfsh_addr_gen_bench.sv
`timescale 1ns/1ps
module rfsh_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] cpuAddr = '0;
  logic        refreshSel = 1'b1;
  logic        outEn = 1'b1;
  logic        charClk;
  wire  [15:0] memBus;
  wire  [3:0]  rasBus;

  for (genvar i = 0; i < 16; i++) begin : g_puMem
    pullup (memBus[i]);
  end
  for (genvar i = 0; i < 4; i++) begin : g_puRas
    pullup (rasBus[i]);
  end

  rfsh_addr_gen u_rfsh_addr_gen (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cpuAddr(cpuAddr), .refreshSel(refreshSel), .outEn(outEn),
    .charClk(charClk), .memAddr(memBus), .rasterAddr(rasBus)
  );

  always #10 clk = ~clk;

  int  cyc = 0;
  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  typedef struct packed {
    logic        gr;
    logic [2:0]  hp;
    logic [3:0]  vp;
    logic [6:0]  hn;
    logic [7:0]  nx;
    logic [15:0] st;
    logic [15:0] at;
    logic [15:0] addr;
    logic [3:0]  ras;
    logic        ck;
    logic [3:0]  req;
  } vec_t;

  // A: graphic Hp=4 HN=2 Nx=2 start 0010 (offset 4)
  // B: character Hp=5 Vp=2 HN=3 Nx=4 start FFFE (offset 6)
  // C: graphic Hp=8 HN=2 Nx=3 start 1000 (offset 6)
  localparam vec_t VECS [16] = '{
    '{1'b1, 3'd3, 4'd0, 7'd1, 8'd1, 16'h0010, 16'd0,   16'h0010, 4'd0, 1'b0, 4'd2}, // R2 upper
    '{1'b1, 3'd3, 4'd0, 7'd1, 8'd1, 16'h0010, 16'd2,   16'h0014, 4'd0, 1'b1, 4'd1}, // R1 phase
    '{1'b1, 3'd3, 4'd0, 7'd1, 8'd1, 16'h0010, 16'd5,   16'h0011, 4'd0, 1'b0, 4'd3}, // R3 step
    '{1'b1, 3'd3, 4'd0, 7'd1, 8'd1, 16'h0010, 16'd39,  16'h001D, 4'd0, 1'b1, 4'd3}, // R3 dead
    '{1'b1, 3'd3, 4'd0, 7'd1, 8'd1, 16'h0010, 16'd41,  16'h0012, 4'd0, 1'b0, 4'd4}, // R4
    '{1'b1, 3'd3, 4'd0, 7'd1, 8'd1, 16'h0010, 16'd80,  16'h0010, 4'd0, 1'b0, 4'd6}, // R6
    '{1'b0, 3'd4, 4'd1, 7'd2, 8'd3, 16'hFFFE, 16'd0,   16'hFFFE, 4'd0, 1'b0, 4'd2}, // R2
    '{1'b0, 3'd4, 4'd1, 7'd2, 8'd3, 16'hFFFE, 16'd3,   16'h0004, 4'd0, 1'b1, 4'd7}, // R7 wrap
    '{1'b0, 3'd4, 4'd1, 7'd2, 8'd3, 16'hFFFE, 16'd56,  16'hFFFE, 4'd1, 1'b0, 4'd5}, // R5 repeat
    '{1'b0, 3'd4, 4'd1, 7'd2, 8'd3, 16'hFFFE, 16'd112, 16'h0007, 4'd0, 1'b1, 4'd5}, // R5 next row
    '{1'b0, 3'd4, 4'd1, 7'd2, 8'd3, 16'hFFFE, 16'd186, 16'h0005, 4'd1, 1'b0, 4'd5}, // R5
    '{1'b0, 3'd4, 4'd1, 7'd2, 8'd3, 16'hFFFE, 16'd220, 16'hFFFE, 4'd0, 1'b0, 4'd6}, // R6
    '{1'b1, 3'd7, 4'd0, 7'd1, 8'd2, 16'h1000, 16'd4,   16'h1006, 4'd0, 1'b1, 4'd1}, // R1 Hp=8
    '{1'b1, 3'd7, 4'd0, 7'd1, 8'd2, 16'h1000, 16'd191, 16'h100D, 4'd0, 1'b1, 4'd3}, // R3
    '{1'b1, 3'd7, 4'd0, 7'd1, 8'd2, 16'h1000, 16'd240, 16'h1000, 4'd0, 1'b0, 4'd6}, // R6
    '{1'b1, 3'd3, 4'd0, 7'd1, 8'd1, 16'h0010, 16'd79,  16'h001F, 4'd0, 1'b1, 4'd6}  // R6 last fetch
  };

  task automatic tick();
    @(posedge clk);
    cyc++;
    #5;
  endtask

  task automatic runTo(input int n);
    while (cyc < n) tick();
  endtask

  task automatic wrReg(input logic [3:0] idx, input logic [7:0] val);
    wrEn = 1'b1; regSel = 1'b1; wrData = {4'd0, idx};
    tick();
    regSel = 1'b0; wrData = val;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
    cyc = 0;
  endtask

  task automatic setup(input vec_t v);
    wrReg(4'd0, {7'd0, v.gr});
    wrReg(4'd1, {5'd0, v.hp});
    wrReg(4'd2, {4'd0, v.vp});
    wrReg(4'd3, {1'b0, v.hn});
    wrReg(4'd4, v.nx);
    wrReg(4'd5, v.st[7:0]);
    wrReg(4'd6, v.st[15:8]);
    doReset();
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    string tag;
    doReset();
    // R11: index register cleared by reset
    regSel = 1'b1;
    #1;
    check(rdData == 8'h00, "R11", "index after reset", rdData, 0);

    // table walk
    for (int k = 0; k < 16; k++) begin
      setup(VECS[k]);
      runTo(int'(VECS[k].at));
      tag = $sformatf("R%0d", VECS[k].req);
      check(memBus == VECS[k].addr, tag, $sformatf("vec%0d memAddr", k),
            memBus, VECS[k].addr);
      check(rasBus == VECS[k].ras, tag, $sformatf("vec%0d rasterAddr", k),
            rasBus, VECS[k].ras);
      check(charClk == VECS[k].ck, tag, $sformatf("vec%0d charClk", k),
            charClk, VECS[k].ck);
    end

    // R11: reset clears index, keeps configuration (last vector graphic=1)
    wrEn = 1'b1; regSel = 1'b1; wrData = 8'h06;
    tick();
    wrEn = 1'b0;
    doReset();
    regSel = 1'b1;
    #1;
    check(rdData == 8'h00, "R11", "index cleared", rdData, 0);
    regSel = 1'b0;
    #1;
    check(rdData == 8'h01, "R11", "mode kept", rdData, 1);

    // R10: readback masks and unused indices
    wrReg(4'd3, 8'hFF);
    #1;
    check(rdData == 8'h7F, "R10", "HN field mask", rdData, 8'h7F);
    wrReg(4'd1, 8'hFF);
    #1;
    check(rdData == 8'h07, "R10", "Hp field mask", rdData, 8'h07);
    wrReg(4'd9, 8'h55);
    #1;
    check(rdData == 8'h00, "R10", "unused index", rdData, 0);
    regSel = 1'b1;
    #1;
    check(rdData == 8'h09, "R10", "index readback", rdData, 9);
    regSel = 1'b0;

    // R8: CPU address on the bus
    refreshSel = 1'b0; cpuAddr = 16'h1234;
    tick();
    check(memBus == 16'h1234, "R8", "cpu address", memBus, 16'h1234);
    // R9: float, pulled up by the bench
    outEn = 1'b0; cpuAddr = 16'h0000;
    tick();
    check(memBus == 16'hFFFF, "R9", "memAddr floating", memBus, 16'hFFFF);
    check(rasBus == 4'hF, "R9", "rasterAddr floating", rasBus, 4'hF);
    outEn = 1'b1;
    tick();
    check(memBus == 16'h0000, "R8", "cpu address after float", memBus, 0);
    refreshSel = 1'b1;

    // R6: start written mid-frame takes effect at next frame
    setup(VECS[0]);
    runTo(20);
    wrReg(4'd5, 8'h00);
    wrReg(4'd6, 8'h02);
    runTo(41);
    check(memBus == 16'h0012, "R6", "old start kept in frame", memBus, 16'h0012);
    runTo(81);
    check(memBus == 16'h0200, "R6", "new start next frame", memBus, 16'h0200);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule